// File: doc/BRIEF.md
# Issue Queue with Result-Tag Wakeup

This block sits between instruction dispatch and the functional units of an out-of-order core. It holds dispatched instructions until both of their source operands are known. Beside the queue it keeps a register status file: for every architectural register, a value, a pending flag and the tag of the instruction that will produce the register's next value. At dispatch each source register is looked up. A register that is not pending supplies its value and the slot is ready at once. A pending register supplies its producer tag and the slot waits. The dispatched instruction then claims its destination register by writing its own tag there.

A single result broadcast per cycle carries a producer tag and a value. In the same cycle the tag is compared against every waiting operand slot of every entry and against every pending register. Each slot that matches takes the value and becomes ready. A register takes the value only if its pending tag still equals the broadcast tag. If a younger instruction has claimed the register since, the register ignores the broadcast. Every cycle the block presents the oldest entry whose two sources are both ready, and that entry leaves the queue at the next clock edge.

A read port lets the surrounding logic, or a bench, observe the status of any register.

Top module: `iqWake`

## Requirements
- R1: After reset the queue is empty, `issueValid` and `dispFull` are 0, and every register reads pending 0 with value 0.
- R2: An accepted dispatch marks its destination register pending with `dispDstTag` from the next cycle on. A source register that is not pending gives that slot its register value and makes the slot ready. A pending source register makes the slot wait on that register's tag.
- R3: A broadcast with `bcValid` high is compared in the same cycle with every waiting slot of every entry. Every matching slot takes `bcValue` and becomes ready. Slots that do not match are unchanged.
- R4: A pending register whose tag equals the broadcast tag takes `bcValue` and reads pending 0 from the next cycle.
- R5: A pending register whose tag differs from the broadcast tag keeps its value, its tag and its pending flag.
- R6: An entry is presented on the issue outputs only when both of its sources are ready. The presented operands are the captured values, in source order A then B.
- R7: When several entries are eligible, the one dispatched earliest is presented. At most one entry is presented per cycle. A presented entry leaves the queue at the next clock edge.
- R8: A dispatch whose pending source tag matches a broadcast in the same cycle captures the broadcast value and is ready at once.
- R9: `dispFull` is 1 while the queue holds `DEPTH` entries. A dispatch offered while `dispFull` is 1 is ignored: no entry is added and its destination register is not claimed.
- R10: While `bcValid` is 0, the broadcast tag and value have no effect on any slot or register.
- R11: A dispatch whose source register is also its destination register reads that register's status from before the claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dispValid | input | 1 | Dispatch request this cycle |
| dispOp | input | OP_W | Opcode of the dispatched instruction |
| dispDstReg | input | REG_W | Destination register claimed by the dispatch |
| dispDstTag | input | TAG_W | Tag under which the dispatch will broadcast its result |
| dispSrcAReg | input | REG_W | First source register |
| dispSrcBReg | input | REG_W | Second source register |
| dispFull | output | 1 | Queue holds DEPTH entries; dispatch is refused |
| bcValid | input | 1 | Result broadcast qualifier |
| bcTag | input | TAG_W | Producer tag of the broadcast result |
| bcValue | input | DATA_W | Broadcast result value |
| issueValid | output | 1 | An eligible entry is presented |
| issueOp | output | OP_W | Opcode of the presented entry |
| issueDstTag | output | TAG_W | Destination tag of the presented entry |
| issueSrcA | output | DATA_W | First operand value of the presented entry |
| issueSrcB | output | DATA_W | Second operand value of the presented entry |
| rdReg | input | REG_W | Register selected on the status read port |
| rdValue | output | DATA_W | Value of the selected register |
| rdPending | output | 1 | Pending flag of the selected register |
| rdTag | output | TAG_W | Pending producer tag of the selected register |

## Verification
The bench builds the block with its defaults: four queue entries, eight registers, 3-bit tags, 16-bit data and 4-bit opcodes. Four entries let a few dispatches fill the queue, so the refusal at full and the release of entries out of dispatch order can both be reached in a short run. Eight registers and eight tags are enough to re-tag a register while its older producer is still outstanding, and to wake two dependent entries with a single broadcast.

// File: rtl/iqPkg.sv
`timescale 1ns/1ps
package iqPkg;
  // strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic dispWe;     // accepted dispatch writes an entry and claims a register
    logic issueFire;  // presented entry leaves the queue at this edge
  } iqStrobe_t;
endpackage

// File: rtl/iqRegStatus.sv
`timescale 1ns/1ps
module iqRegStatus #(
  parameter int REGS   = 8,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16,
  parameter int RD_N   = 3,
  localparam int REG_W = $clog2(REGS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        bcValid,
  input  logic [TAG_W-1:0]            bcTag,
  input  logic [DATA_W-1:0]           bcValue,
  input  logic                        renameWe,
  input  logic [REG_W-1:0]            renameReg,
  input  logic [TAG_W-1:0]            renameTag,
  input  logic [RD_N-1:0][REG_W-1:0]  rdAddr,
  output logic [RD_N-1:0]             rdPend,
  output logic [RD_N-1:0][TAG_W-1:0]  rdTag,
  output logic [RD_N-1:0][DATA_W-1:0] rdVal
);
  logic [REGS-1:0]             pendV;
  logic [REGS-1:0][TAG_W-1:0]  tagV;
  logic [REGS-1:0][DATA_W-1:0] valV;

  for (genvar r = 0; r < REGS; r++) begin : gReg
    logic              pendR;
    logic [TAG_W-1:0]  tagR;
    logic [DATA_W-1:0] valR;
    logic              hit;
    logic              claim;

    // a register only accepts the result of the producer it still waits for
    assign hit   = bcValid && pendR && (tagR == bcTag);
    assign claim = renameWe && (renameReg == REG_W'(r));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        pendR <= 1'b0;
        tagR  <= '0;
        valR  <= '0;
      end else begin
        if (hit) valR <= bcValue;
        pendR <= claim || (pendR && !hit);
        if (claim) tagR <= renameTag;
      end
    end

    assign pendV[r] = pendR;
    assign tagV[r]  = tagR;
    assign valV[r]  = valR;
  end

  for (genvar p = 0; p < RD_N; p++) begin : gRd
    assign rdPend[p] = pendV[rdAddr[p]];
    assign rdTag[p]  = tagV[rdAddr[p]];
    assign rdVal[p]  = valV[rdAddr[p]];
  end
endmodule

// File: rtl/iqEntries.sv
`timescale 1ns/1ps
module iqEntries
  import iqPkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int SRC_N = 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  iqStrobe_t                    strobe,
  input  logic [IDX_W-1:0]             wrPos,
  input  logic [IDX_W-1:0]             issueIdx,
  input  logic [OP_W-1:0]              dispOp,
  input  logic [TAG_W-1:0]             dispDstTag,
  input  logic [SRC_N-1:0]             srcPend,
  input  logic [SRC_N-1:0][TAG_W-1:0]  srcTag,
  input  logic [SRC_N-1:0][DATA_W-1:0] srcVal,
  input  logic                         bcValid,
  input  logic [TAG_W-1:0]             bcTag,
  input  logic [DATA_W-1:0]            bcValue,
  output logic [DEPTH-1:0]             entReady,
  output logic [OP_W-1:0]              issueOp,
  output logic [TAG_W-1:0]             issueDstTag,
  output logic [DATA_W-1:0]            issueSrcA,
  output logic [DATA_W-1:0]            issueSrcB
);
  // slot 0 is the oldest entry; issue collapses the younger ones down by one
  logic [DEPTH-1:0][OP_W-1:0]              opV;
  logic [DEPTH-1:0][TAG_W-1:0]             dstV;
  logic [DEPTH-1:0][SRC_N-1:0]             rdyV;
  logic [DEPTH-1:0][SRC_N-1:0][TAG_W-1:0]  tagV;
  logic [DEPTH-1:0][SRC_N-1:0][DATA_W-1:0] valV;

  // operand state for a new entry, bypassing a broadcast of the same cycle
  logic [SRC_N-1:0]             initRdy;
  logic [SRC_N-1:0][DATA_W-1:0] initVal;

  for (genvar s = 0; s < SRC_N; s++) begin : gInit
    logic catchNow;
    assign catchNow   = srcPend[s] && bcValid && (srcTag[s] == bcTag);
    assign initRdy[s] = !srcPend[s] || catchNow;
    assign initVal[s] = srcPend[s] ? bcValue : srcVal[s];
  end

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    localparam int NXT = (i < DEPTH - 1) ? i + 1 : i;
    logic              take;
    logic              load;
    logic [OP_W-1:0]   opR;
    logic [TAG_W-1:0]  dstR;

    assign take = strobe.issueFire && (i >= int'(issueIdx));
    assign load = strobe.dispWe && (wrPos == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        opR  <= '0;
        dstR <= '0;
      end else if (load) begin
        opR  <= dispOp;
        dstR <= dispDstTag;
      end else if (take) begin
        opR  <= opV[NXT];
        dstR <= dstV[NXT];
      end
    end

    assign opV[i]  = opR;
    assign dstV[i] = dstR;

    for (genvar s = 0; s < SRC_N; s++) begin : gSrc
      logic              rdyR;
      logic [TAG_W-1:0]  tagR;
      logic [DATA_W-1:0] valR;
      logic              hRdy;
      logic [TAG_W-1:0]  hTag;
      logic [DATA_W-1:0] hVal;
      logic              wake;

      always_comb begin
        hRdy = take ? rdyV[NXT][s] : rdyR;
        hTag = take ? tagV[NXT][s] : tagR;
        hVal = take ? valV[NXT][s] : valR;
        wake = !hRdy && bcValid && (hTag == bcTag);
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          rdyR <= 1'b0;
          tagR <= '0;
          valR <= '0;
        end else if (load) begin
          rdyR <= initRdy[s];
          tagR <= srcTag[s];
          valR <= initVal[s];
        end else begin
          rdyR <= hRdy || wake;
          tagR <= hTag;
          valR <= wake ? bcValue : hVal;
        end
      end

      assign rdyV[i][s] = rdyR;
      assign tagV[i][s] = tagR;
      assign valV[i][s] = valR;
    end

    assign entReady[i] = &rdyV[i];
  end

  assign issueOp     = opV[issueIdx];
  assign issueDstTag = dstV[issueIdx];
  assign issueSrcA   = valV[issueIdx][0];
  assign issueSrcB   = valV[issueIdx][1];
endmodule

// File: rtl/iqCtrl.sv
`timescale 1ns/1ps
module iqCtrl
  import iqPkg::*;
#(
  parameter int DEPTH  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dispValid,
  input  logic [DEPTH-1:0] entReady,
  output logic             dispFull,
  output logic             issueValid,
  output iqStrobe_t        strobe,
  output logic [IDX_W-1:0] wrPos,
  output logic [IDX_W-1:0] issueIdx
);
  logic [CNT_W-1:0] count;
  logic [DEPTH-1:0] occupied;
  logic [DEPTH-1:0] eligible;

  always_comb begin
    for (int j = 0; j < DEPTH; j++) occupied[j] = (j < int'(count));
    eligible = entReady & occupied;
    issueIdx = '0;
    for (int j = DEPTH - 1; j >= 0; j--) begin
      if (eligible[j]) issueIdx = IDX_W'(j);
    end
  end

  assign dispFull         = (count == CNT_W'(DEPTH));
  assign issueValid       = |eligible;
  assign strobe.issueFire = issueValid;
  assign strobe.dispWe    = dispValid && !dispFull;
  assign wrPos            = IDX_W'(count - CNT_W'(strobe.issueFire));

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else       count <= count + CNT_W'(strobe.dispWe) - CNT_W'(strobe.issueFire);
  end
endmodule

// File: rtl/iqWake.sv
`timescale 1ns/1ps
module iqWake
  import iqPkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int REGS   = 8,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16,
  localparam int REG_W = $clog2(REGS),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dispValid,
  input  logic [OP_W-1:0]   dispOp,
  input  logic [REG_W-1:0]  dispDstReg,
  input  logic [TAG_W-1:0]  dispDstTag,
  input  logic [REG_W-1:0]  dispSrcAReg,
  input  logic [REG_W-1:0]  dispSrcBReg,
  output logic              dispFull,
  input  logic              bcValid,
  input  logic [TAG_W-1:0]  bcTag,
  input  logic [DATA_W-1:0] bcValue,
  output logic              issueValid,
  output logic [OP_W-1:0]   issueOp,
  output logic [TAG_W-1:0]  issueDstTag,
  output logic [DATA_W-1:0] issueSrcA,
  output logic [DATA_W-1:0] issueSrcB,
  input  logic [REG_W-1:0]  rdReg,
  output logic [DATA_W-1:0] rdValue,
  output logic              rdPending,
  output logic [TAG_W-1:0]  rdTag
);
  iqStrobe_t               strobe;
  logic [IDX_W-1:0]        wrPos;
  logic [IDX_W-1:0]        issueIdx;
  logic [DEPTH-1:0]        entReady;
  logic [2:0][REG_W-1:0]   rsAddr;
  logic [2:0]              rsPend;
  logic [2:0][TAG_W-1:0]   rsTag;
  logic [2:0][DATA_W-1:0]  rsVal;

  assign rsAddr = {rdReg, dispSrcBReg, dispSrcAReg};

  iqCtrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .entReady(entReady),
    .dispFull(dispFull), .issueValid(issueValid), .strobe(strobe),
    .wrPos(wrPos), .issueIdx(issueIdx)
  );

  iqRegStatus #(.REGS(REGS), .TAG_W(TAG_W), .DATA_W(DATA_W), .RD_N(3)) regs_i (
    .clk(clk), .rstN(rstN), .bcValid(bcValid), .bcTag(bcTag), .bcValue(bcValue),
    .renameWe(strobe.dispWe), .renameReg(dispDstReg), .renameTag(dispDstTag),
    .rdAddr(rsAddr), .rdPend(rsPend), .rdTag(rsTag), .rdVal(rsVal)
  );

  iqEntries #(.DEPTH(DEPTH), .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) ent_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrPos(wrPos), .issueIdx(issueIdx),
    .dispOp(dispOp), .dispDstTag(dispDstTag),
    .srcPend(rsPend[1:0]), .srcTag(rsTag[1:0]), .srcVal(rsVal[1:0]),
    .bcValid(bcValid), .bcTag(bcTag), .bcValue(bcValue),
    .entReady(entReady), .issueOp(issueOp), .issueDstTag(issueDstTag),
    .issueSrcA(issueSrcA), .issueSrcB(issueSrcB)
  );

  assign rdValue   = rsVal[2];
  assign rdPending = rsPend[2];
  assign rdTag     = rsTag[2];
endmodule

// File: rtl/iqWakeChk.sv
`timescale 1ns/1ps
module iqWakeChk #(
  parameter int REG_W  = 3,
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              dispValid,
  input logic [REG_W-1:0]  dispDstReg,
  input logic [TAG_W-1:0]  dispDstTag,
  input logic              dispFull,
  input logic              bcValid,
  input logic [TAG_W-1:0]  bcTag,
  input logic [DATA_W-1:0] bcValue,
  input logic              issueValid,
  input logic [REG_W-1:0]  rdReg,
  input logic [DATA_W-1:0] rdValue,
  input logic              rdPending,
  input logic [TAG_W-1:0]  rdTag
);
  logic claimsRd;
  assign claimsRd = dispValid && !dispFull && (dispDstReg == rdReg);

  // R2: an accepted dispatch leaves its destination pending on its own tag
  assert_claim_R2: assert property (@(posedge clk) disable iff (!rstN)
    claimsRd |=> (rdReg != $past(rdReg)) || (rdPending && rdTag == $past(dispDstTag)));

  // R4: matching broadcast completes the register
  assert_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    (bcValid && rdPending && rdTag == bcTag && !claimsRd)
    |=> (rdReg != $past(rdReg)) || (!rdPending && rdValue == $past(bcValue)));

  // R5: a register waiting on another producer ignores the broadcast
  assert_keep_R5: assert property (@(posedge clk) disable iff (!rstN)
    (bcValid && rdPending && rdTag != bcTag && !claimsRd)
    |=> (rdReg != $past(rdReg)) ||
        (rdPending && rdTag == $past(rdTag) && rdValue == $past(rdValue)));

  // R9: a full queue with nothing leaving stays full whatever is offered
  assert_full_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dispFull && !issueValid) |=> dispFull);
endmodule

bind iqWake iqWakeChk #(.REG_W(REG_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispDstReg(dispDstReg),
  .dispDstTag(dispDstTag), .dispFull(dispFull), .bcValid(bcValid), .bcTag(bcTag),
  .bcValue(bcValue), .issueValid(issueValid), .rdReg(rdReg), .rdValue(rdValue),
  .rdPending(rdPending), .rdTag(rdTag)
);

// File: tb/iqWake_tb_top.sv
`timescale 1ns/1ps
module iqWake_tb_top;
  localparam int OP_W = 4, TAG_W = 3, DATA_W = 16, REG_W = 3, REGS = 8;
  localparam int ROWS = 27;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dispValid = 1'b0;
  logic [OP_W-1:0] dispOp = '0;
  logic [REG_W-1:0] dispDstReg = '0, dispSrcAReg = '0, dispSrcBReg = '0, rdReg = '0;
  logic [TAG_W-1:0] dispDstTag = '0, bcTag = '0;
  logic bcValid = 1'b0;
  logic [DATA_W-1:0] bcValue = '0;
  logic dispFull, issueValid, rdPending;
  logic [OP_W-1:0] issueOp;
  logic [TAG_W-1:0] issueDstTag, rdTag;
  logic [DATA_W-1:0] issueSrcA, issueSrcB, rdValue;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;  // 250 MHz

  iqWake dut_i (
    .clk(clk), .rstN(rstN), .dispValid(dispValid), .dispOp(dispOp),
    .dispDstReg(dispDstReg), .dispDstTag(dispDstTag), .dispSrcAReg(dispSrcAReg),
    .dispSrcBReg(dispSrcBReg), .dispFull(dispFull), .bcValid(bcValid), .bcTag(bcTag),
    .bcValue(bcValue), .issueValid(issueValid), .issueOp(issueOp),
    .issueDstTag(issueDstTag), .issueSrcA(issueSrcA), .issueSrcB(issueSrcB),
    .rdReg(rdReg), .rdValue(rdValue), .rdPending(rdPending), .rdTag(rdTag)
  );

  typedef struct packed {
    logic dv; logic [3:0] op; logic [2:0] dreg; logic [2:0] dtag;
    logic [2:0] sa; logic [2:0] sb;
    logic bv; logic [2:0] btag; logic [15:0] bval; logic [2:0] rreg;
    logic iv; logic [3:0] iop; logic [2:0] itag; logic [15:0] ia; logic [15:0] ib;
    logic full; logic rpend; logic [15:0] rval;
    logic [3:0] req;
  } row_t;

  // inputs applied before an edge; outputs expected just after it
  // dv op dreg dtag sa sb | bv btag bval | rreg || iv iop itag ia ib | full rpend rval | req
  localparam row_t TBL [ROWS] = '{
    '{1,1,1,1,0,0, 0,0,'h00, 1, 1,1,1,'h00,'h00, 0,1,'h00, 2},   // R2 ready sources, claim reg1
    '{0,0,0,0,0,0, 1,1,'h11, 1, 0,0,0,'h00,'h00, 0,0,'h11, 4},   // R4 reg1 completes
    '{1,2,2,2,1,3, 0,0,'h00, 2, 1,2,2,'h11,'h00, 0,1,'h00, 2},   // R2 register values read
    '{1,3,3,3,2,1, 0,0,'h00, 3, 0,0,0,'h00,'h00, 0,1,'h00, 6},   // R6 waits on tag2
    '{1,4,4,4,3,2, 1,2,'h22, 2, 1,3,3,'h22,'h11, 0,0,'h22, 8},   // R8 bypass plus R3 wake
    '{0,0,0,0,0,0, 1,3,'h33, 3, 1,4,4,'h33,'h22, 0,0,'h33, 3},   // R3 wake while shifting
    '{0,0,0,0,0,0, 0,0,'h00, 4, 0,0,0,'h00,'h00, 0,1,'h00, 7},   // R7 entry left
    '{1,5,4,5,4,0, 0,0,'h00, 4, 0,0,0,'h00,'h00, 0,1,'h00, 2},   // R2 re-claim reg4 tag5
    '{0,0,0,0,0,0, 1,4,'h44, 4, 1,5,5,'h44,'h00, 0,1,'h00, 5},   // R5 stale tag ignored
    '{0,0,0,0,0,0, 0,0,'h00, 4, 0,0,0,'h00,'h00, 0,1,'h00, 7},   // R7 queue drains
    '{0,0,0,0,0,0, 1,5,'h55, 4, 0,0,0,'h00,'h00, 0,0,'h55, 4},   // R4 newer producer
    '{1,6,5,6,4,4, 0,6,'h66, 5, 1,6,6,'h55,'h55, 0,1,'h00, 10},  // R10 invalid bc
    '{0,0,0,0,0,0, 0,6,'h66, 5, 0,0,0,'h00,'h00, 0,1,'h00, 10},  // R10 reg5 untouched
    '{0,0,0,0,0,0, 1,6,'h66, 5, 0,0,0,'h00,'h00, 0,0,'h66, 4},   // R4
    '{1,8,6,7,6,6, 0,0,'h00, 6, 1,8,7,'h00,'h00, 0,1,'h00, 11},  // R11 src equals dst
    '{1,9,7,1,6,0, 0,0,'h00, 7, 0,0,0,'h00,'h00, 0,1,'h00, 2},   // R2 waits on tag7
    '{1,10,1,2,7,0, 0,0,'h00, 1, 0,0,0,'h00,'h00, 0,1,'h11, 2},
    '{1,11,2,3,1,0, 0,0,'h00, 2, 0,0,0,'h00,'h00, 0,1,'h22, 2},
    '{1,12,3,4,2,0, 0,0,'h00, 3, 0,0,0,'h00,'h00, 1,1,'h33, 9},  // R9 full
    '{1,13,0,5,0,0, 0,0,'h00, 0, 0,0,0,'h00,'h00, 1,0,'h00, 9},  // R9 refused, reg0 free
    '{0,0,0,0,0,0, 1,3,'hC3, 2, 1,12,4,'hC3,'h00, 1,0,'hC3, 3},  // R3 youngest wakes
    '{0,0,0,0,0,0, 1,1,'hA1, 7, 1,10,2,'hA1,'h00, 0,0,'hA1, 7},  // R7 middle entry
    '{1,14,5,6,0,6, 1,7,'hB7, 6, 1,9,1,'hB7,'h00, 0,0,'hB7, 7},  // R7 oldest first, R8
    '{0,0,0,0,0,0, 0,0,'h00, 5, 1,14,6,'h00,'hB7, 0,1,'h66, 8},  // R8 bypassed operand
    '{0,0,0,0,0,0, 0,0,'h00, 5, 0,0,0,'h00,'h00, 0,1,'h66, 7},
    '{0,0,0,0,0,0, 1,2,'hB2, 1, 1,11,3,'hB2,'h00, 0,0,'hB2, 3},  // R3 last waiter
    '{0,0,0,0,0,0, 0,0,'h00, 1, 0,0,0,'h00,'h00, 0,0,'hB2, 6}    // R6 queue empty
  };

  task automatic drive(input row_t r);
    dispValid = r.dv; dispOp = r.op; dispDstReg = r.dreg; dispDstTag = r.dtag;
    dispSrcAReg = r.sa; dispSrcBReg = r.sb;
    bcValid = r.bv; bcTag = r.btag; bcValue = r.bval; rdReg = r.rreg;
  endtask

  task automatic checkRow(input int idx, input row_t r);
    logic bad;
    checks++;
    bad = (issueValid !== r.iv) || (dispFull !== r.full) ||
          (rdPending !== r.rpend) || (rdValue !== r.rval);
    if (r.iv && ((issueOp !== r.iop) || (issueDstTag !== r.itag) ||
                 (issueSrcA !== r.ia) || (issueSrcB !== r.ib))) bad = 1'b1;
    if (bad) begin
      errors++;
      $display("FAIL R%0d row %0d actual iv=%0b op=%0h tag=%0h a=%h b=%h full=%0b pend=%0b val=%h expected iv=%0b op=%0h tag=%0h a=%h b=%h full=%0b pend=%0b val=%h",
               r.req, idx, issueValid, issueOp, issueDstTag, issueSrcA, issueSrcB,
               dispFull, rdPending, rdValue, r.iv, r.iop, r.itag, r.ia, r.ib,
               r.full, r.rpend, r.rval);
    end
  endtask

  task automatic checkVal(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    drive('0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic checkResetState();
    checkVal("R1", "issueValid", int'(issueValid), 0);
    checkVal("R1", "dispFull", int'(dispFull), 0);
    for (int r = 0; r < REGS; r++) begin
      rdReg = REG_W'(r);
      #1;
      checkVal("R1", $sformatf("reg%0d pending", r), int'(rdPending), 0);
      checkVal("R1", $sformatf("reg%0d value", r), int'(rdValue), 0);
    end
  endtask

  task automatic step(input row_t r);
    @(negedge clk);
    drive(r);
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    row_t r;
    doReset();
    checkResetState();

    for (int i = 0; i < ROWS; i++) begin
      step(TBL[i]);
      checkRow(i, TBL[i]);
    end

    // R9: fill with four waiting entries behind one ready producer
    r = '0;
    r.dv = 1; r.op = 1; r.dreg = 1; r.dtag = 5; r.sa = 0; r.sb = 0;
    step(r);
    for (int k = 0; k < 4; k++) begin
      r = '0;
      r.dv = 1; r.op = 4'(k + 2); r.dreg = 3'(k + 2); r.dtag = 3'(k + 1); r.sa = 1; r.sb = 0;
      step(r);
    end
    checkVal("R9", "dispFull after four waiters", int'(dispFull), 1);
    checkVal("R6", "no issue while waiting", int'(issueValid), 0);

    // R1: reset mid-run clears queue and register claims
    doReset();
    checkResetState();

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule